// File: doc/BRIEF.md
# Signed Fractional Multiply-Add Cell

This cell is the repeated processing element of a systolic elimination array. On every clock it accepts three two's-complement fractions `x`, `y` and `z`. Each value has its binary point just right of the sign bit, so it lies in the range [-1, 1). The cell returns `w = x*y + z`. It also hands `x` and `y` on unchanged, so that neighbouring cells in the same row and column receive them in step with the result.

The product is formed by a regular array of full adders. Partial products that pair exactly one sign bit with a magnitude bit are inverted, and two constant ones are injected so that the signed sum comes out right. The addend `z` does not go through a separate adder after the product. It is folded in by one extra full-adder row at the bottom of the array. The double-width sum is cut back to `WIDTH` bits by keeping the sign position and the `WIDTH-1` fraction bits below it; lower bits are dropped and anything that does not fit wraps.

Registers on the inputs and on the outputs keep neighbouring array rows aligned. A new operand set can enter every cycle, and its result appears two clock edges later. A synchronous reset clears every boundary register.

Top module: `fxp_mac_cell`

## Requirements
- R1: `out_w` equals bits [2*WIDTH-2 : WIDTH-1] of the exact integer sum `x*y + z*2^(WIDTH-1)`, where `x`, `y` and `z` are the signed input words captured two edges earlier.
- R2: `out_x` equals the `in_x` sampled two clock edges earlier.
- R3: `out_y` equals the `in_y` sampled two clock edges earlier.
- R4: When `rst` is high at a rising edge, all three outputs are zero after that edge, whatever the inputs are.
- R5: In the cycle that follows the first edge with `rst` low, all outputs are still zero, because the cleared input registers feed the array.
- R6: A new operand set is accepted at every edge, and back-to-back sets produce back-to-back results with no stall or interference.
- R7: If `x` or `y` is zero, `out_w` equals `z`.
- R8: If `x` is the most negative code (only the top bit set) and `z` is zero, `out_w` equals `-y` modulo 2^WIDTH. In particular, (-1)*(-1) wraps to the most negative code.
- R9: Dropped low-order bits round toward minus infinity. A negative product smaller than one LSB, with `z` zero, gives all ones; a positive one gives zero.
- R10: A sum outside [-1, 1) wraps modulo 2^WIDTH and is not saturated. For example, with WIDTH=8, x=0x40, y=0x40 and z=0x7F, the result is 0x9F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_x | input | WIDTH | Multiplicand fraction |
| in_y | input | WIDTH | Multiplier fraction |
| in_z | input | WIDTH | Addend fraction |
| out_x | output | WIDTH | Forwarded multiplicand |
| out_y | output | WIDTH | Forwarded multiplier |
| out_w | output | WIDTH | Truncated result x*y + z |

## Verification
The hardest cases to reach through the ports are the ones that exercise the sign-correction path at its edges. These are (-1)*(-1), where the only representable outcome is a wrap, and tiny negative products whose truncation must borrow all the way up into the kept bits. Random fractions almost never land on them. A directed vector table therefore places them next to each other and streams them back to back, one per cycle, so that a pipeline mix-up would also show. Reset is asserted while non-zero operands sit on the inputs, which separates the clear at the reset edge from the cleared-register result in the cycle after release.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

    // One-bit full adder: sum output
    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    // One-bit full adder: majority carry
    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction

endpackage

// File: rtl/fxp_fa_row.sv
// One row of full adders, rippling carries; the carry out of the top is dropped (modulo 2^LEN).
module fxp_fa_row
    import fxp_mac_pkg::*;
#(
    parameter int unsigned LEN = 16
) (
    input  logic [LEN-1:0] a,
    input  logic [LEN-1:0] b,
    output logic [LEN-1:0] s
);
    logic [LEN-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar k = 0; k < LEN; k++) begin : g_bit
        assign s[k] = fa_sum(a[k], b[k], cy[k]);
        if (k < LEN - 1) begin : g_cy
            assign cy[k+1] = fa_carry(a[k], b[k], cy[k]);
        end
    end
endmodule

// File: rtl/fxp_pp_matrix.sv
// Partial-product rows with sign correction: bits pairing exactly one sign bit are inverted,
// and constant ones are placed at columns WIDTH and 2*WIDTH-1 (carried in row 0).
module fxp_pp_matrix #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PW   = 2 * WIDTH
) (
    input  logic [WIDTH-1:0]       mcand,
    input  logic [WIDTH-1:0]       mplier,
    output logic [WIDTH-1:0][PW-1:0] rows
);
    always_comb begin
        rows = '0;
        for (int i = 0; i < int'(WIDTH); i++) begin
            for (int j = 0; j < int'(WIDTH); j++) begin
                logic pp;
                pp = mcand[j] & mplier[i];
                if ((i == int'(WIDTH) - 1) != (j == int'(WIDTH) - 1)) begin
                    pp = ~pp;
                end
                rows[i][i+j] = pp;
            end
        end
        rows[0][WIDTH]  = 1'b1;
        rows[0][PW-1]   = 1'b1;
    end
endmodule

// File: rtl/fxp_mac_array.sv
// Chains WIDTH-1 full-adder rows for the product, then one more row that adds the aligned addend.
module fxp_mac_array #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PW   = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    input  logic [WIDTH-1:0] op_z,
    output logic [PW-1:0]    sum
);
    logic [WIDTH-1:0][PW-1:0] pp_rows;
    logic [PW-1:0]            acc [WIDTH];
    logic [PW-1:0]            z_aligned;

    fxp_pp_matrix #(.WIDTH(WIDTH)) pp_i (
        .mcand  (op_x),
        .mplier (op_y),
        .rows   (pp_rows)
    );

    assign acc[0] = pp_rows[0];

    for (genvar r = 1; r < WIDTH; r++) begin : g_row
        fxp_fa_row #(.LEN(PW)) row_i (
            .a (acc[r-1]),
            .b (pp_rows[r]),
            .s (acc[r])
        );
    end

    // Addend sits at the product's binary point: shifted up by WIDTH-1, sign extended by one bit.
    assign z_aligned = {op_z[WIDTH-1], op_z, {(WIDTH-1){1'b0}}};

    fxp_fa_row #(.LEN(PW)) add_row_i (
        .a (acc[WIDTH-1]),
        .b (z_aligned),
        .s (sum)
    );
endmodule

// File: rtl/fxp_mac_cell.sv
module fxp_mac_cell #(
    parameter int unsigned WIDTH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [WIDTH-1:0] in_x,
    input  logic signed [WIDTH-1:0] in_y,
    input  logic signed [WIDTH-1:0] in_z,
    output logic signed [WIDTH-1:0] out_x,
    output logic signed [WIDTH-1:0] out_y,
    output logic signed [WIDTH-1:0] out_w
);
    localparam int unsigned PW = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] x_in;
        logic [WIDTH-1:0] y_in;
        logic [WIDTH-1:0] z_in;
        logic [WIDTH-1:0] x_out;
        logic [WIDTH-1:0] y_out;
        logic [WIDTH-1:0] w_out;
    } cell_state_t;

    cell_state_t   state_d, state_q;
    logic [PW-1:0] sum_full;
    logic          unused_sum_bits;

    fxp_mac_array #(.WIDTH(WIDTH)) array_i (
        .op_x (state_q.x_in),
        .op_y (state_q.y_in),
        .op_z (state_q.z_in),
        .sum  (sum_full)
    );

    // Top guard bit and the low fraction bits are discarded by truncation.
    assign unused_sum_bits = ^{sum_full[PW-1], sum_full[WIDTH-2:0]};

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = '0;
        end else begin
            state_d.x_in  = in_x;
            state_d.y_in  = in_y;
            state_d.z_in  = in_z;
            state_d.x_out = state_q.x_in;
            state_d.y_out = state_q.y_in;
            state_d.w_out = sum_full[PW-2:WIDTH-1];
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign out_x = state_q.x_out;
    assign out_y = state_q.y_out;
    assign out_w = state_q.w_out;
endmodule

// File: rtl/fxp_mac_cell_chk.sv
module fxp_mac_cell_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [WIDTH-1:0] in_x,
    input logic signed [WIDTH-1:0] in_y,
    input logic signed [WIDTH-1:0] in_z,
    input logic signed [WIDTH-1:0] out_x,
    input logic signed [WIDTH-1:0] out_y,
    input logic signed [WIDTH-1:0] out_w
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    // Edges seen since reset released, saturating at 2 (pipeline filled with real inputs).
    logic [1:0] fill_q;
    always_ff @(posedge clk) begin
        if (rst)                fill_q <= 2'd0;
        else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end

    p_reset_clear_r4: assert property (@(posedge clk)
        rst |=> (out_w == '0 && out_x == '0 && out_y == '0));

    p_release_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (out_w == '0 && out_x == '0 && out_y == '0));

    p_fwd_x_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_q == 2'd2) |-> (out_x == $past(in_x, 2)));

    p_fwd_y_r3: assert property (@(posedge clk) disable iff (rst)
        (fill_q == 2'd2) |-> (out_y == $past(in_y, 2)));

    p_zero_factor_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_q == 2'd2 && ($past(in_x, 2) == '0 || $past(in_y, 2) == '0))
        |-> (out_w == $past(in_z, 2)));

    p_neg_one_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_q == 2'd2 && $past(in_x, 2) == MOST_NEG && $past(in_z, 2) == '0)
        |-> (out_w == WIDTH'('0 - $past(in_y, 2))));
endmodule

bind fxp_mac_cell fxp_mac_cell_chk #(.WIDTH(WIDTH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .in_x  (in_x),
    .in_y  (in_y),
    .in_z  (in_z),
    .out_x (out_x),
    .out_y (out_y),
    .out_w (out_w)
);

// File: tb/fxp_mac_cell_tb_top.sv
`timescale 1ns/1ps
module fxp_mac_cell_tb_top;
    localparam int W      = 8;
    localparam int NV     = 14;
    localparam int NR     = 200;
    localparam int LIMIT  = 20000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [W-1:0] in_x = '0, in_y = '0, in_z = '0;
    logic signed [W-1:0] out_x, out_y, out_w;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fxp_mac_cell #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_x(out_x), .out_y(out_y), .out_w(out_w)
    );

    // {x, y, z, expected w}, hand-computed for WIDTH = 8
    localparam logic [4*W-1:0] VEC [NV] = '{
        32'h40_40_00_20,  // R1 0.5*0.5
        32'h40_C0_00_E0,  // R1 0.5*-0.5
        32'h40_40_7F_9F,  // R10 wrap past +1
        32'h80_80_00_80,  // R8 -1*-1 wraps
        32'h80_30_00_D0,  // R8 -1*y = -y
        32'h01_FF_00_FF,  // R9 tiny negative floors to -LSB
        32'h01_01_00_00,  // R9 tiny positive floors to 0
        32'h00_5A_33_33,  // R7 x zero
        32'h7F_00_C4_C4,  // R7 y zero
        32'h60_60_E0_28,  // R1 with negative addend
        32'hC0_C0_10_30,  // R1 neg*neg plus addend
        32'h80_80_80_00,  // R1 wrap cancelled by addend
        32'h7F_7F_00_7E,  // R9 largest product, floor
        32'h81_7F_00_81   // R9 negative product, floor
    };

    function automatic logic [W-1:0] ref_w(input logic signed [W-1:0] a,
                                           input logic signed [W-1:0] b,
                                           input logic signed [W-1:0] c);
        logic signed [2*W+1:0] full;
        logic signed [2*W+1:0] cz;
        full = a * b;
        cz   = c;
        full = full + (cz <<< (W-1));
        return full[2*W-2:W-1];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [W-1:0] rx [NR];
    logic [W-1:0] ry [NR];
    logic [W-1:0] rz [NR];

    initial begin
        // R4: reset with non-zero operands present
        in_x = 8'h55; in_y = 8'h66; in_z = 8'h77;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 w in reset", out_w, '0);
        check("R4 x in reset", out_x, '0);
        check("R4 y in reset", out_y, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R5 w after release", out_w, '0);
        check("R5 x after release", out_x, '0);
        @(negedge clk);
        check("R1 first result", out_w, ref_w(8'sh55, 8'sh66, 8'sh77));
        check("R2 first x", out_x, 8'h55);
        check("R3 first y", out_y, 8'h66);

        // R6: table streamed one vector per cycle
        for (int k = 0; k < NV + 2; k++) begin
            if (k >= 2) begin
                check("R6 table w", out_w, VEC[k-2][W-1:0]);
                check("R2 table x", out_x, VEC[k-2][4*W-1:3*W]);
                check("R3 table y", out_y, VEC[k-2][3*W-1:2*W]);
            end
            if (k < NV) begin
                in_x = VEC[k][4*W-1:3*W];
                in_y = VEC[k][3*W-1:2*W];
                in_z = VEC[k][2*W-1:W];
            end
            @(negedge clk);
        end

        // R1: random fractions, streamed
        for (int k = 0; k < NR; k++) begin
            rx[k] = W'($urandom);
            ry[k] = W'($urandom);
            rz[k] = W'($urandom);
        end
        for (int k = 0; k < NR + 2; k++) begin
            if (k >= 2) begin
                check("R1 random w", out_w, ref_w(rx[k-2], ry[k-2], rz[k-2]));
                check("R2 random x", out_x, rx[k-2]);
                check("R3 random y", out_y, ry[k-2]);
            end
            if (k < NR) begin
                in_x = rx[k]; in_y = ry[k]; in_z = rz[k];
            end
            @(negedge clk);
        end

        // R4 mid-stream reset, then R5 again
        in_x = 8'h7F; in_y = 8'h7F; in_z = 8'h01;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R4 w mid reset", out_w, '0);
        check("R4 y mid reset", out_y, '0);
        rst = 1'b0;
        in_x = 8'h80; in_y = 8'h80; in_z = 8'h00;
        @(negedge clk);
        check("R5 w second release", out_w, '0);
        @(negedge clk);
        check("R8 -1*-1 after release", out_w, 8'h80);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule